// File: doc/BRIEF.md
# Half-Duplex SPI Transaction Engine

This block is a register-controlled SPI master meant for serial NOR flash style traffic, where each transaction sends a command, then optional payload, then reads a response. Software writes up to four command/address bytes into a command register and up to 32 payload bytes into an eight-word data buffer. It then programs one packed length register with three bit counts: command, payload and response. Writing the start bit launches a run. The engine clocks out the command bits, then the payload bits, then clocks in the response bits. The response bits overwrite the same data buffer, and software can poll a busy flag to see when the run has finished.

The chip-select line is driven only by its own software register. Runs never touch it. Software can therefore hold the select low across any number of consecutive runs and build one long SPI message out of many short runs, including runs that only write and runs that only read. The serial clock is SPI mode 0. Each half period lasts a programmable number of system clocks.

The sequencer has four states. IDLE waits for a start. CMD shifts command bits. WDATA shifts payload bits. RDATA samples response bits. The transitions are:
- start: IDLE goes to the first state whose length is non-zero. If all three lengths are zero it stays in IDLE.
- cmd_done: CMD goes to WDATA, RDATA or IDLE, again skipping any empty phase.
- wdata_done: WDATA goes to RDATA or IDLE.
- rdata_done: RDATA goes to IDLE.

A phase ends on the serial clock falling edge that closes its last bit.

Top module: `spi_hd_engine`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0 and mosi is 0, and every register reads back as zero: control, command, length, select and divider.
- R2: cs_n equals the inverse of bit 0 of the select register (word address 3). It changes only after a write to that register and keeps its level through any number of runs.
- R3: Writing a 1 to bit 0 of the control register (word address 0) while idle starts a run. Reading bit 0 of the control register returns 1 from the next cycle until the run ends. A start written during a run is ignored and produces no extra clock pulses.
- R4: Phases run in the order command, payload, response, and a phase with a zero length is skipped. If all three lengths are zero, no clock pulse is produced and busy never rises.
- R5: In the length register (word address 2), bits [29:24] hold the command length in bits, bits [8:0] hold the payload length and bits [20:12] hold the response length. The command length is clamped to 32 and the other two to 256. A run produces exactly as many rising sclk edges as the sum of the clamped lengths.
- R6: A command length of n bits sends bits n-1 down to 0 of the command register (word address 1). A 3-byte command therefore sits in the low 24 bits and its highest byte is sent first.
- R7: Payload bit j is byte j/8 of the data buffer, taken MSB first. Buffer byte b is bits 8*(b mod 4)+7..8*(b mod 4) of data word b/4, at word addresses 8 to 15.
- R8: Response bit j is sampled on a rising sclk edge and written to the same buffer position as payload bit j. Buffer bits beyond the response length keep their values.
- R9: sclk idles low and toggles only during a run. Each high and each low half lasts divider+1 system clocks (divider register at word address 4, 8 bits). mosi changes only while sclk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| sclk | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Active-low chip select from the select register |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
Randomised runs draw each of the three lengths independently, sometimes above the clamp limits and sometimes not a multiple of eight, with random buffer contents and divider values. A wrong phase order, a skipped phase or a wrong per-byte bit index then shows up as a mismatch against the bench's own bit-stream model. Directed runs cover cases that each isolate one rule:
- A 3-byte command exposes the command byte order.
- An all-zero length word checks that an empty run produces no clock.
- Saturated fields check clamping.
- A timed run with divider 3 checks the half-period length.
- A second start written mid-run checks that only one run happens.
- Back-to-back runs under one held select check that runs leave chip select alone.

The device model returns a pseudo-random bit stream indexed by falling edge. A response bit read from the wrong edge or stored at the wrong buffer position therefore differs from the expected buffer.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;
    localparam int WORD_W      = 32;
    localparam int BUF_WORDS   = 8;
    localparam int BUF_BITS    = BUF_WORDS * WORD_W;
    localparam int CMD_BYTES   = 4;
    localparam int CMD_MAX     = CMD_BYTES * 8;
    localparam int LEN_W       = 9;
    localparam int POS_W       = $clog2(BUF_BITS);
    localparam int CMD_POS_W   = $clog2(CMD_MAX);
    localparam int DIV_W       = 8;
    localparam int ADDR_W      = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMD  = 4'd1;
    localparam logic [ADDR_W-1:0] A_LEN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_SEL  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DIV  = 4'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } phase_e;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v,
                                                   input logic [LEN_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction
endpackage

// File: rtl/spi_hd_clkdiv.sv
module spi_hd_clkdiv
    import spi_hd_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          sclk,
    output logic          rise_tick,
    output logic          fall_tick
);
    logic [DW-1:0] cnt_q;
    logic          half_q;
    logic          wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= div;
            half_q <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q  <= div;
            half_q <= ~half_q;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign wrap      = run && (cnt_q == '0);
    assign rise_tick = wrap && !half_q;
    assign fall_tick = wrap && half_q;
    assign sclk      = half_q;
endmodule

// File: rtl/spi_hd_regs.sv
module spi_hd_regs
    import spi_hd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic                 busy,
    input  logic                 cap_we,
    input  logic [POS_W-1:0]     cap_pos,
    input  logic                 cap_bit,
    output logic                 start,
    output logic [WORD_W-1:0]    cmd_q,
    output logic [WORD_W-1:0]    len_q,
    output logic [DIV_W-1:0]     div_q,
    output logic                 sel_q,
    output logic [BUF_BITS-1:0]  buf_q
);
    logic is_buf;
    assign is_buf = bus_addr[ADDR_W-1];
    assign start  = bus_we && (bus_addr == A_CTRL) && bus_wdata[0] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            len_q <= '0;
            div_q <= '0;
            sel_q <= 1'b0;
            buf_q <= '0;
        end else begin
            if (bus_we) begin
                if (is_buf) begin
                    buf_q[{bus_addr[ADDR_W-2:0], 5'b0} +: WORD_W] <= bus_wdata;
                end else begin
                    case (bus_addr)
                        A_CMD:   cmd_q <= bus_wdata;
                        A_LEN:   len_q <= bus_wdata;
                        A_DIV:   div_q <= bus_wdata[DIV_W-1:0];
                        A_SEL:   sel_q <= bus_wdata[0];
                        default: ;
                    endcase
                end
            end
            if (cap_we) begin
                buf_q[cap_pos] <= cap_bit;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (is_buf) begin
            bus_rdata = buf_q[{bus_addr[ADDR_W-2:0], 5'b0} +: WORD_W];
        end else begin
            case (bus_addr)
                A_CTRL:  bus_rdata = {{(WORD_W-1){1'b0}}, busy};
                A_CMD:   bus_rdata = cmd_q;
                A_LEN:   bus_rdata = len_q;
                A_DIV:   bus_rdata = {{(WORD_W-DIV_W){1'b0}}, div_q};
                A_SEL:   bus_rdata = {{(WORD_W-1){1'b0}}, sel_q};
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/spi_hd_seq.sv
module spi_hd_seq
    import spi_hd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [5:0]          cmd_field,
    input  logic [LEN_W-1:0]    wr_field,
    input  logic [LEN_W-1:0]    rd_field,
    input  logic [WORD_W-1:0]   cmd_q,
    input  logic [BUF_BITS-1:0] buf_q,
    input  logic                rise_tick,
    input  logic                fall_tick,
    output logic                run,
    output logic                mosi,
    output logic                cap_we,
    output logic [POS_W-1:0]    cap_pos
);
    phase_e          state;
    logic [LEN_W-1:0] cmd_n, wr_n, rd_n, bit_idx, cur_len;
    logic [LEN_W-1:0] cmd_req, wr_req, rd_req;
    logic [CMD_POS_W-1:0] cmd_sel;
    logic [POS_W-1:0]     buf_sel;

    assign cmd_req = clamp_len({3'b0, cmd_field}, LEN_W'(CMD_MAX));
    assign wr_req  = clamp_len(wr_field, LEN_W'(BUF_BITS));
    assign rd_req  = clamp_len(rd_field, LEN_W'(BUF_BITS));

    function automatic phase_e pick(input logic [LEN_W-1:0] c, w, r, input phase_e from);
        if (from == ST_IDLE && c != '0) return ST_CMD;
        if ((from == ST_IDLE || from == ST_CMD) && w != '0) return ST_WDATA;
        if (from != ST_RDATA && r != '0) return ST_RDATA;
        return ST_IDLE;
    endfunction

    always_comb begin
        unique case (state)
            ST_CMD:   cur_len = cmd_n;
            ST_WDATA: cur_len = wr_n;
            ST_RDATA: cur_len = rd_n;
            default:  cur_len = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cmd_n   <= '0;
            wr_n    <= '0;
            rd_n    <= '0;
            bit_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cmd_n   <= cmd_req;
                        wr_n    <= wr_req;
                        rd_n    <= rd_req;
                        bit_idx <= '0;
                        state   <= pick(cmd_req, wr_req, rd_req, ST_IDLE);
                    end
                end
                ST_CMD, ST_WDATA, ST_RDATA: begin
                    if (fall_tick) begin
                        if (bit_idx == cur_len - 1'b1) begin
                            bit_idx <= '0;
                            state   <= pick(cmd_n, wr_n, rd_n, state);
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign cmd_sel = CMD_POS_W'(cmd_n - 1'b1 - bit_idx);
    assign buf_sel = bit_idx[POS_W-1:0] ^ POS_W'(7);

    always_comb begin
        run     = 1'b0;
        mosi    = 1'b0;
        cap_we  = 1'b0;
        cap_pos = buf_sel;
        unique case (state)
            ST_IDLE:  ;
            ST_CMD:   begin run = 1'b1; mosi = cmd_q[cmd_sel]; end
            ST_WDATA: begin run = 1'b1; mosi = buf_q[buf_sel]; end
            ST_RDATA: begin run = 1'b1; cap_we = rise_tick; end
        endcase
    end
endmodule

// File: rtl/spi_hd_engine.sv
module spi_hd_engine
    import spi_hd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    logic                busy, start, cap_we, sel_q, rise_tick, fall_tick;
    logic [POS_W-1:0]    cap_pos;
    logic [WORD_W-1:0]   cmd_q, len_q;
    logic [DIV_W-1:0]    div_q;
    logic [BUF_BITS-1:0] buf_q;

    spi_hd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .cap_we(cap_we), .cap_pos(cap_pos), .cap_bit(miso), .start(start),
        .cmd_q(cmd_q), .len_q(len_q), .div_q(div_q), .sel_q(sel_q), .buf_q(buf_q)
    );

    spi_hd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_field(len_q[29:24]), .wr_field(len_q[8:0]), .rd_field(len_q[20:12]),
        .cmd_q(cmd_q), .buf_q(buf_q), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .run(busy), .mosi(mosi), .cap_we(cap_we), .cap_pos(cap_pos)
    );

    spi_hd_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
        .sclk(sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    assign cs_n = ~sel_q;
endmodule

// File: rtl/spi_hd_chk.sv
module spi_hd_chk
    import spi_hd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              sclk,
    input logic              cs_n,
    input logic              mosi,
    input logic              busy
);
    // R2
    cs_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n) |-> $past(bus_we && bus_addr == A_SEL));

    // R9
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R9
    sclk_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> busy);

    // R9
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R3
    busy_end_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(sclk));
endmodule

bind spi_hd_engine spi_hd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy)
);

// File: tb/sim_spi_hd_engine.sv
module sim_spi_hd_engine;
    import spi_hd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, cs_n, mosi, miso;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int rise_cnt = 0;
    int fall_cnt = 0;
    int rbase = 0;
    int fbase = 0;
    logic [31:0] seed = 32'h1;
    logic mos_log [0:1023];

    always #4 clk = ~clk;

    spi_hd_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    function automatic logic seqbit(input int n, input logic [31:0] s);
        logic [31:0] h;
        h = (n * 32'h9E3779B1) ^ s;
        h = h ^ (h >> 13);
        return h[7];
    endfunction

    assign miso = seqbit(fall_cnt - fbase, seed);

    always @(posedge sclk) begin
        if ((rise_cnt - rbase) >= 0 && (rise_cnt - rbase) < 1024)
            mos_log[rise_cnt - rbase] = mosi;
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge sclk) fall_cnt = fall_cnt + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        int n = 0;
        do begin
            rd(A_CTRL, d);
            n++;
        end while (d[0] && n < 20000);
    endtask

    function automatic int lim(input int v, input int m);
        return (v > m) ? m : v;
    endfunction

    task automatic run_case(input int cf, input int wf, input int rf, input logic [31:0] cmd,
                            input int dv, input logic [31:0] sd);
        logic [255:0] bufi, bufe, bufr;
        logic [31:0] d;
        int cn, wn, rn, bad_c, bad_w;
        wr(A_DIV, 32'(dv));
        wr(A_CMD, cmd);
        wr(A_LEN, (32'(cf) << 24) | (32'(rf) << 12) | 32'(wf));
        for (int i = 0; i < 8; i++) begin
            bufi[32*i +: 32] = $urandom;
            wr(4'(8 + i), bufi[32*i +: 32]);
        end
        cn = lim(cf, 32); wn = lim(wf, 256); rn = lim(rf, 256);
        seed = sd;
        rbase = rise_cnt; fbase = fall_cnt;
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, d);
        chk(d[0] == ((cn + wn + rn) != 0), "R3 busy after start", longint'(d[0]),
            longint'((cn + wn + rn) != 0));
        wait_idle();
        chk((rise_cnt - rbase) == cn + wn + rn, "R5 rising edge count",
            rise_cnt - rbase, cn + wn + rn);
        bad_c = 0; bad_w = 0;
        for (int k = 0; k < cn; k++)
            if (mos_log[k] !== cmd[cn - 1 - k]) bad_c++;
        for (int j = 0; j < wn; j++)
            if (mos_log[cn + j] !== bufi[j ^ 7]) bad_w++;
        chk(bad_c == 0, "R6 command bit order", bad_c, 0);
        chk(bad_w == 0, "R7 payload bit order", bad_w, 0);
        bufe = bufi;
        for (int j = 0; j < rn; j++) bufe[j ^ 7] = seqbit(cn + wn + j, sd);
        for (int i = 0; i < 8; i++) begin
            rd(4'(8 + i), d);
            bufr[32*i +: 32] = d;
        end
        chk(bufr == bufe, "R8 response buffer", longint'(bufr[63:0] ^ bufe[63:0]), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        time t0, t1, t2;
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        #1;
        chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R1 reset pins",
            {cs_n, sclk, mosi}, 3'b100);
        rst_n = 1'b1;
        for (int a = 0; a < 5; a++) begin
            rd(4'(a), d);
            chk(d == 0, "R1 reset register", d, 0);
        end

        wr(A_SEL, 32'h1);
        #1 chk(cs_n === 1'b0, "R2 select asserted", cs_n, 0);

        // R6: 3-byte command in the low bytes, high byte first; then a second run, select held (R2)
        run_case(24, 0, 16, 32'h00A1B2C3, 0, 32'h11);
        run_case(0, 40, 24, 32'h0, 1, 32'h22);
        chk(cs_n === 1'b0, "R2 select held across runs", cs_n, 0);

        // R4: all lengths zero
        wr(A_LEN, 32'h0);
        rbase = rise_cnt;
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, d);
        chk(d[0] == 1'b0, "R4 empty run not busy", d[0], 0);
        repeat (4) @(negedge clk);
        chk(rise_cnt == rbase, "R4 empty run no clock", rise_cnt - rbase, 0);

        // R5: saturated fields clamp
        run_case(63, 511, 511, 32'hDEADBEEF, 0, 32'h33);

        // R7: full command plus payload
        run_case(32, 40, 0, 32'h12345678, 2, 32'h44);

        // R9: half-period timing with divider 3
        wr(A_DIV, 32'd3);
        wr(A_LEN, 32'd8 << 24);
        wr(A_CTRL, 32'h1);
        @(posedge sclk); t0 = $time;
        @(negedge sclk); t1 = $time;
        @(posedge sclk); t2 = $time;
        chk((t1 - t0) == 32, "R9 high half length", t1 - t0, 32);
        chk((t2 - t1) == 32, "R9 low half length", t2 - t1, 32);
        wait_idle();

        // R3: start during a run is ignored
        wr(A_DIV, 32'd1);
        wr(A_LEN, (32'd16 << 24) | (32'd8 << 12));
        rbase = rise_cnt;
        wr(A_CTRL, 32'h1);
        repeat (5) @(negedge clk);
        rd(A_CTRL, d);
        chk(d[0] == 1'b1, "R3 busy mid-run", d[0], 1);
        wr(A_CTRL, 32'h1);
        wait_idle();
        repeat (10) @(negedge clk);
        chk((rise_cnt - rbase) == 24, "R3 restart ignored", rise_cnt - rbase, 24);

        // randomised runs
        for (int r = 0; r < 12; r++)
            run_case(int'($urandom % 40), int'($urandom % 300), int'($urandom % 300),
                     $urandom, int'($urandom % 3), $urandom);

        wr(A_SEL, 32'h0);
        #1 chk(cs_n === 1'b1, "R2 select released", cs_n, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule